// File: doc/BRIEF.md
# GPIO Interrupt Detector and Aggregator

This block watches a bank of already-synchronized GPIO inputs and turns per-pin trigger conditions into one interrupt line for a parent controller. Each pin selects one of four trigger modes with two configuration bits: rising edge, falling edge, low level or high level. A detected condition sets that pin's status bit. Software clears status bits by writing ones into a 32-pin word. Pins that firmware has kept for itself never raise status.

A per-pin enable register is written one 32-pin word at a time. The pending set is status AND enable, and the OR of all pending bits drives a registered interrupt output. Level triggers set their status bit again on every cycle while the level stays active, so a clear only takes effect once the level is gone. The pin configuration, the ownership map and the synchronizers live outside this block and arrive here as plain vectors.

Top module: `gpio_irq_agg`

## Requirements
- R1: With trig_level_i=0 and trig_inv_i=0, a 0-to-1 change on pin_i sets that pin's bit in stat_o. The bit is visible on the first clock edge that samples the new pin value.
- R2: With trig_level_i=0 and trig_inv_i=1, a 1-to-0 change sets the status bit, and a 0-to-1 change does not.
- R3: With trig_level_i=1 and trig_inv_i=0, the status bit is set while the pin is low.
- R4: With trig_level_i=1 and trig_inv_i=1, the status bit is set while the pin is high, and not while it is low.
- R5: A clear write selects a word with clr_sel_i; the word holds pins 32*sel to 32*sel+31. Each 1 in clr_data_i clears the matching status bit on the next edge. Each 0 leaves its bit unchanged, and the other words are not affected.
- R6: While a level trigger stays active, its status bit stays set even when it is written with a clear. After the level goes away, a clear removes the bit.
- R7: When a new event and a clear hit the same bit on the same edge, the bit stays set.
- R8: The previous-value register loads the current input during reset. A pin that is high when reset is released therefore shows no edge.
- R9: A pin with owned_i=0 never sets its status bit, whatever its trigger mode or input.
- R10: An enable write loads en_data_i into the word of en_o chosen by en_sel_i. irq_o is a register equal to the OR of (stat_o AND en_o) as it was one cycle earlier. Status bits with no enable do not raise irq_o.
- R11: After reset, stat_o, en_o and irq_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_i | input | NPINS | Synchronized pin levels |
| trig_level_i | input | NPINS | Per pin: 1 selects a level trigger, 0 an edge trigger |
| trig_inv_i | input | NPINS | Per pin: 1 selects falling edge or high level |
| owned_i | input | NPINS | Per pin: 1 if the pin may raise interrupts |
| clr_we_i | input | 1 | Strobe for a write-one-to-clear status write |
| clr_sel_i | input | SEL_W | Word index for the clear write |
| clr_data_i | input | WORD_W | Clear mask for the selected word |
| en_we_i | input | 1 | Strobe for an enable word write |
| en_sel_i | input | SEL_W | Word index for the enable write |
| en_data_i | input | WORD_W | Enable value for the selected word |
| stat_o | output | NPINS | Latched status bits |
| en_o | output | NPINS | Enable register |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
A bad previous-value register shows up as a stray or missing status bit on the edge right after the input moves. The worst case is a bit that appears straight after reset. A bad clear decode shows up as a neighbour bit or another word changing on the edge after the write. A broken enable mask or a broken OR tree shows up on irq_o one cycle after the status changes. Each of these shows at the ports within one or two cycles of its cause, so the bench compares every status bit at every step.

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg #(
  parameter int NPINS  = 95,
  parameter int WORD_W = 32,
  localparam int NWORDS = (NPINS + WORD_W - 1) / WORD_W,
  localparam int SEL_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_i,
  input  logic [NPINS-1:0]  trig_level_i,
  input  logic [NPINS-1:0]  trig_inv_i,
  input  logic [NPINS-1:0]  owned_i,
  input  logic              clr_we_i,
  input  logic [SEL_W-1:0]  clr_sel_i,
  input  logic [WORD_W-1:0] clr_data_i,
  input  logic              en_we_i,
  input  logic [SEL_W-1:0]  en_sel_i,
  input  logic [WORD_W-1:0] en_data_i,
  output logic [NPINS-1:0]  stat_o,
  output logic [NPINS-1:0]  en_o,
  output logic              irq_o
);

  logic [NPINS-1:0] prev_q, clr_hit, en_hit, en_word, evt;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    localparam int W = i / WORD_W;
    localparam int B = i % WORD_W;
    assign clr_hit[i] = clr_we_i && (clr_sel_i == SEL_W'(W)) && clr_data_i[B];
    assign en_hit[i]  = en_we_i && (en_sel_i == SEL_W'(W));
    assign en_word[i] = en_data_i[B];
  end

  wire [NPINS-1:0] rise    = pin_i & ~prev_q;
  wire [NPINS-1:0] fall    = ~pin_i & prev_q;
  wire [NPINS-1:0] lvl_act = ~(pin_i ^ trig_inv_i);
  wire [NPINS-1:0] edg_act = (rise & ~trig_inv_i) | (fall & trig_inv_i);

  assign evt = owned_i & ((trig_level_i & lvl_act) | (~trig_level_i & edg_act));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= pin_i;
      stat_o <= '0;
      en_o   <= '0;
      irq_o  <= 1'b0;
    end else begin
      prev_q <= pin_i;
      stat_o <= evt | (stat_o & ~clr_hit);
      en_o   <= (en_o & ~en_hit) | (en_word & en_hit);
      irq_o  <= |(stat_o & en_o);
    end
  end

  logic unused_bits;
  assign unused_bits = &{1'b0, clr_data_i, en_data_i};

endmodule

// File: rtl/gpio_irq_agg_chk.sv
module gpio_irq_agg_chk #(
  parameter int NPINS  = 95,
  parameter int WORD_W = 32,
  localparam int NWORDS = (NPINS + WORD_W - 1) / WORD_W,
  localparam int SEL_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NPINS-1:0]  pin_i,
  input logic [NPINS-1:0]  trig_level_i,
  input logic [NPINS-1:0]  trig_inv_i,
  input logic [NPINS-1:0]  owned_i,
  input logic              clr_we_i,
  input logic [SEL_W-1:0]  clr_sel_i,
  input logic [WORD_W-1:0] clr_data_i,
  input logic              en_we_i,
  input logic [SEL_W-1:0]  en_sel_i,
  input logic [WORD_W-1:0] en_data_i,
  input logic [NPINS-1:0]  stat_o,
  input logic [NPINS-1:0]  en_o,
  input logic              irq_o
);
  logic [NPINS-1:0] wr_mask;
  always_comb
    for (int i = 0; i < NPINS; i++)
      wr_mask[i] = clr_we_i && (int'(clr_sel_i) == i / WORD_W) && clr_data_i[i % WORD_W];

  wire [NPINS-1:0] lvl_on = owned_i & trig_level_i & ~(pin_i ^ trig_inv_i);

  AST_UNOWNED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((stat_o & ~$past(stat_o) & ~$past(owned_i)) == '0)); // R9
  AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((~stat_o & $past(stat_o) & ~$past(wr_mask)) == '0)); // R5
  AST_LEVEL_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((~stat_o & $past(lvl_on)) == '0)); // R6
  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (irq_o == $past(|(stat_o & en_o)))); // R10
  AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(en_we_i)) |-> $stable(en_o)); // R10
  logic unused_c;
  assign unused_c = &{1'b0, en_sel_i, en_data_i};
endmodule

bind gpio_irq_agg gpio_irq_agg_chk #(.NPINS(NPINS), .WORD_W(WORD_W)) chk_i (.*);

// File: tb/gpio_irq_agg_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_agg_tb_top;
  localparam int N = 95;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] pin = '0, tlev = '0, tinv = '0, own = '1;
  logic clr_we = 0, en_we = 0;
  logic [1:0] clr_sel = 0, en_sel = 0;
  logic [31:0] clr_data = 0, en_data = 0;
  logic [N-1:0] stat, en;
  logic irq;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  gpio_irq_agg dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .trig_level_i(tlev), .trig_inv_i(tinv),
    .owned_i(own), .clr_we_i(clr_we), .clr_sel_i(clr_sel), .clr_data_i(clr_data),
    .en_we_i(en_we), .en_sel_i(en_sel), .en_data_i(en_data),
    .stat_o(stat), .en_o(en), .irq_o(irq));

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic clr_word(int w, logic [31:0] d);
    clr_we = 1; clr_sel = 2'(w); clr_data = d; tick(); clr_we = 0;
  endtask

  task automatic clr_all();
    for (int w = 0; w < 3; w++) clr_word(w, '1);
  endtask

  task automatic t_reset();
    pin[5] = 1;
    repeat (3) tick();
    rst_n = 1;
    chk("R11 stat", stat, 0); chk("R11 en", en, 0); chk("R11 irq", irq, 0);
    tick(); tick();
    chk("R8 no edge after reset", stat, 0);
    pin[5] = 0; tick();
    chk("R1 falling ignored in rise mode", stat, 0);
  endtask

  task automatic t_rise();
    logic [N-1:0] e = '0; e[3] = 1;
    pin[3] = 1; tick();
    chk("R1 rise sets", stat, e);
    pin[3] = 0; clr_all();
    chk("R1 cleared, no event on fall", stat, 0);
  endtask

  task automatic t_fall();
    logic [N-1:0] e = '0; e[40] = 1;
    tinv[40] = 1; pin[40] = 1; tick();
    chk("R2 rise ignored", stat, 0);
    pin[40] = 0; tick();
    chk("R2 fall sets", stat, e);
    clr_word(1, 32'h100);
    chk("R2 cleared", stat, 0);
    tinv[40] = 0;
  endtask

  task automatic t_low();
    logic [N-1:0] e = '0; e[70] = 1;
    tlev[70] = 1; tick();
    chk("R3 low level sets", stat, e);
    clr_word(2, 32'h40);
    chk("R6 clear while active", stat, e);
    pin[70] = 1; tick();
    chk("R6 still latched", stat, e);
    clr_word(2, 32'h40);
    chk("R6 clear after release", stat, 0);
    tlev[70] = 0; pin[70] = 0; tick();
  endtask

  task automatic t_high();
    logic [N-1:0] e = '0; e[94] = 1;
    tlev[94] = 1; tinv[94] = 1; tick();
    chk("R4 low ignored", stat, 0);
    pin[94] = 1; tick();
    chk("R4 high sets", stat, e);
    pin[94] = 0; tick(); clr_word(2, '1);
    chk("R4 cleared", stat, 0);
    tlev[94] = 0; tinv[94] = 0;
  endtask

  task automatic t_w1c();
    logic [N-1:0] e = '0; e[2] = 1;
    pin[1] = 1; pin[2] = 1; tick();
    clr_word(0, 32'h2);
    chk("R5 only bit1 cleared", stat, e);
    clr_word(1, '1);
    chk("R5 other word untouched", stat, e);
    clr_word(0, 32'h0);
    chk("R5 zero write no effect", stat, e);
    pin[1] = 0; pin[2] = 0; clr_all();
    chk("R5 all cleared", stat, 0);
  endtask

  task automatic t_collide();
    logic [N-1:0] e = '0; e[10] = 1;
    pin[10] = 1; clr_we = 1; clr_sel = 0; clr_data = 32'h400; tick(); clr_we = 0;
    chk("R7 event wins", stat, e);
    pin[10] = 0; clr_all();
  endtask

  task automatic t_owned();
    own[20] = 0; pin[20] = 1; tick();
    chk("R9 unowned edge", stat, 0);
    tlev[20] = 1; tinv[20] = 1; tick(); tick();
    chk("R9 unowned level", stat, 0);
    pin[20] = 0; tlev[20] = 0; tinv[20] = 0; tick(); own[20] = 1; tick();
  endtask

  task automatic t_irq();
    logic [N-1:0] e = '0;
    en_we = 1; en_sel = 0; en_data = 32'h8; tick(); en_we = 0;
    e[3] = 1; chk("R10 enable word", en, e);
    pin[4] = 1; tick(); tick();
    chk("R10 masked bit no irq", irq, 0);
    pin[3] = 1; tick();
    chk("R10 irq one cycle late", irq, 0);
    tick();
    chk("R10 irq high", irq, 1);
    clr_word(0, 32'h8);
    chk("R10 irq held one cycle", irq, 1);
    tick();
    chk("R10 irq low", irq, 0);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset(); t_rise(); t_fall(); t_low(); t_high();
    t_w1c(); t_collide(); t_owned(); t_irq();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule